// File: doc/BRIEF.md
# Memory-Mapped Word Queue

This block is a single-clock first-in first-out queue of 32-bit words with two ways in and out. Software reaches it through a small register window on a valid/ready bus: a write to the data register enqueues a word, and a read of the data register dequeues one. A read of the status register returns the fill level and the full and empty flags. A hardware agent uses direct push and pop ports that share the same storage. In a typical system, software feeds one side and the agent drains the other, or the reverse.

The storage is an inferred RAM with a registered read port, so every dequeued word appears one cycle after the request. A push into a full queue is still taken when a pop happens in the same cycle, because the pop frees the slot. The register window spans 16 bytes. Only two word offsets are decoded; the others read as zero and ignore writes. When the bus and the agent ask for the same direction in one cycle, the bus wins.

Top module: `mmio_fifo_queue`

## Requirements
- R1: After reset the queue holds no words: hw_empty is 1, hw_full is 0, and a status read returns 0x00000001.
- R2: Words leave in the order they entered, whichever of the bus data register (offset 0x0 write) or hw_push delivered them.
- R3: A bus read is answered with bus_rvalid exactly one cycle after it is presented. A successful hw_pop raises hw_pop_valid with the word on hw_pop_data exactly one cycle later.
- R4: When the queue is full, a push in the same cycle as a successful pop is accepted, and the queue stays full.
- R5: A push while full without a pop in the same cycle is dropped (hw_push_ack stays 0). A pop while empty is dropped: a bus data read then returns 0, and hw_pop_valid stays 0.
- R6: The status register at offset 0x4 holds empty in bit 0, full in bit 1, and the word count from bit 2 upward, with all higher bits zero. It shows the state before any operation in the same cycle. hw_empty and hw_full follow the same flags.
- R7: Reads at offsets other than 0x0 and 0x4 return zero, and writes to them change nothing.
- R8: If the bus and the agent push in the same cycle, only the bus word is queued and hw_push_ack is 0. If both pop in the same cycle, only the bus receives the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus request present |
| bus_ready | output | 1 | Request accepted (always 1) |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 4 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read response valid |
| bus_rdata | output | 32 | Read response data |
| hw_push | input | 1 | Agent push request |
| hw_push_data | input | 32 | Agent push word |
| hw_push_ack | output | 1 | Agent push taken this cycle |
| hw_pop | input | 1 | Agent pop request |
| hw_pop_valid | output | 1 | Popped word valid for the agent |
| hw_pop_data | output | 32 | Popped word |
| hw_empty | output | 1 | Queue empty |
| hw_full | output | 1 | Queue full |

## Verification
hw_push_ack is combinational, so it is due in the same cycle as the request. The bench samples it one nanosecond after it drives the inputs, well before the next rising edge. Bus read responses, agent pop data and changes to the flags all come one register later. The bench therefore drives each request on a falling edge, lets one rising edge pass, and compares these outputs on the following falling edge against a queue model that has already applied that cycle's pop and push. Status values are predicted from the model's state before the operation, which matches the rule that status reflects the state at the time of the request.

// File: rtl/mmio_fifo_pkg.sv
package mmio_fifo_pkg;

  localparam int WORD_W = 32;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFS_DATA = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_STAT = 4'h4;

  // kind of response held for the cycle after a bus read
  typedef enum logic [1:0] {
    RSP_NONE = 2'd0,
    RSP_DATA = 2'd1,
    RSP_STAT = 2'd2,
    RSP_ZERO = 2'd3
  } rsp_kind_e;

  // status word: count above the two flag bits
  function automatic logic [WORD_W-1:0] pack_status(input logic is_empty,
                                                    input logic is_full,
                                                    input logic [WORD_W-3:0] fill);
    return {fill, is_full, is_empty};
  endfunction

  // advance a slot index with wrap at an arbitrary depth
  function automatic int unsigned wrap_next(input int unsigned cur, input int unsigned depth);
    return (cur == depth - 1) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/mfq_ptr_ctrl.sv
module mfq_ptr_ctrl #(
  parameter int DEPTH = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  import mmio_fifo_pkg::*;

  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return AW'(wrap_next(int'(p), DEPTH));
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign pop_ok  = pop_req & ~empty;
  // a pop in the same cycle frees the slot a full queue needs
  assign push_ok = push_req & (~full | pop_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= bump(wr_q);
      if (pop_ok)  rd_q <= bump(rd_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign wr_addr = wr_q;
  assign rd_addr = rd_q;
  assign count   = cnt_q;

endmodule

// File: rtl/mfq_store.sv
module mfq_store #(
  parameter int DEPTH = 64,
  parameter int W = 32,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] rd_q;

  // read-first: a same-address write returns the old word
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rd_q <= mem[raddr];
  end

  assign rdata = rd_q;

endmodule

// File: rtl/mfq_bus_regs.sv
module mfq_bus_regs #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [3:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  input  logic          hw_push,
  input  logic [31:0]   hw_push_data,
  input  logic          hw_pop,
  input  logic          empty,
  input  logic          full,
  input  logic [CW-1:0] count,
  input  logic          pop_ok,
  input  logic [31:0]   ram_rdata,
  output logic          bus_rd,
  output logic          bus_push,
  output logic          bus_pop,
  output logic          hw_push_fwd,
  output logic          hw_pop_fwd,
  output logic          push_req,
  output logic          pop_req,
  output logic [31:0]   push_data,
  output logic          bus_rvalid,
  output logic [31:0]   bus_rdata,
  output logic          hw_pop_valid
);
  import mmio_fifo_pkg::*;

  logic      hit_data, hit_stat, bus_wr;
  rsp_kind_e rsp_q;
  logic [31:0] stat_q;
  logic      hwv_q;

  assign bus_rd   = bus_valid & ~bus_write;
  assign bus_wr   = bus_valid & bus_write;
  assign hit_data = (bus_addr == OFS_DATA);
  assign hit_stat = (bus_addr == OFS_STAT);

  assign bus_pop  = bus_rd & hit_data;
  assign bus_push = bus_wr & hit_data;

  // the bus takes precedence over the agent in each direction
  assign hw_pop_fwd  = hw_pop & ~bus_pop;
  assign hw_push_fwd = hw_push & ~bus_push;
  assign push_req    = bus_push | hw_push_fwd;
  assign pop_req     = bus_pop | hw_pop_fwd;
  assign push_data   = bus_push ? bus_wdata : hw_push_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_q  <= RSP_NONE;
      stat_q <= '0;
      hwv_q  <= 1'b0;
    end else begin
      if (!bus_rd)        rsp_q <= RSP_NONE;
      else if (hit_data)  rsp_q <= (pop_ok ? RSP_DATA : RSP_ZERO);
      else if (hit_stat)  rsp_q <= RSP_STAT;
      else                rsp_q <= RSP_ZERO;
      stat_q <= pack_status(empty, full, 30'(count));
      hwv_q  <= hw_pop_fwd & pop_ok;
    end
  end

  assign bus_rvalid = (rsp_q != RSP_NONE);

  always_comb begin
    case (rsp_q)
      RSP_DATA: bus_rdata = ram_rdata;
      RSP_STAT: bus_rdata = stat_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign hw_pop_valid = hwv_q;

endmodule

// File: rtl/mmio_fifo_queue.sv
module mmio_fifo_queue #(
  parameter int DEPTH = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  output logic        bus_ready,
  input  logic        bus_write,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic        bus_rvalid,
  output logic [31:0] bus_rdata,
  input  logic        hw_push,
  input  logic [31:0] hw_push_data,
  output logic        hw_push_ack,
  input  logic        hw_pop,
  output logic        hw_pop_valid,
  output logic [31:0] hw_pop_data,
  output logic        hw_empty,
  output logic        hw_full
);
  import mmio_fifo_pkg::*;

  // named internal events, also used by the checker
  logic          bus_rd, bus_push, bus_pop, hw_push_fwd, hw_pop_fwd;
  logic          push_req, pop_req, push_ok, pop_ok;
  logic          empty, full;
  logic [CW-1:0] occ;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [31:0]   push_data, ram_rdata;

  mfq_bus_regs #(.DEPTH(DEPTH)) u_regs (
    .clk, .rst_n, .bus_valid, .bus_write, .bus_addr, .bus_wdata,
    .hw_push, .hw_push_data, .hw_pop,
    .empty, .full, .count(occ), .pop_ok, .ram_rdata,
    .bus_rd, .bus_push, .bus_pop, .hw_push_fwd, .hw_pop_fwd,
    .push_req, .pop_req, .push_data,
    .bus_rvalid, .bus_rdata, .hw_pop_valid
  );

  mfq_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk, .rst_n, .push_req, .pop_req, .push_ok, .pop_ok,
    .wr_addr, .rd_addr, .count(occ), .empty, .full
  );

  mfq_store #(.DEPTH(DEPTH), .W(WORD_W)) u_store (
    .clk, .we(push_ok), .waddr(wr_addr), .wdata(push_data),
    .re(pop_ok), .raddr(rd_addr), .rdata(ram_rdata)
  );

  assign bus_ready   = 1'b1;
  assign hw_push_ack = hw_push_fwd & push_ok;
  assign hw_pop_data = ram_rdata;
  assign hw_empty    = empty;
  assign hw_full     = full;

endmodule

// File: rtl/mmio_fifo_queue_chk.sv
module mmio_fifo_queue_chk #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_rd,
  input logic          bus_push,
  input logic          hw_push,
  input logic          hw_push_ack,
  input logic          hw_pop_fwd,
  input logic          push_req,
  input logic          pop_req,
  input logic          push_ok,
  input logic          pop_ok,
  input logic          empty,
  input logic          full,
  input logic [CW-1:0] occ,
  input logic          bus_rvalid,
  input logic          hw_pop_valid
);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (occ == '0) && empty);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) <= DEPTH);

  assert_drop_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_req && !pop_ok) |=> full && $stable(occ));

  assert_drop_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop_req && !push_req) |=> empty);

  assert_full_swap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_ok && pop_ok) |=> full);

  assert_pop_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_pop_fwd && pop_ok) |=> hw_pop_valid);

  assert_bus_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  assert_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({empty, full}));

  assert_bus_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_push && hw_push) |-> !hw_push_ack);

endmodule

bind mmio_fifo_queue mmio_fifo_queue_chk #(.DEPTH(DEPTH)) u_chk (
  .clk, .rst_n, .bus_rd, .bus_push, .hw_push, .hw_push_ack, .hw_pop_fwd,
  .push_req, .pop_req, .push_ok, .pop_ok, .empty, .full, .occ,
  .bus_rvalid, .hw_pop_valid
);

// File: tb/mmio_fifo_queue_bench.sv
module mmio_fifo_queue_bench;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        hw_push = 1'b0, hw_pop = 1'b0;
  logic [31:0] hw_push_data = '0;
  logic        bus_ready, bus_rvalid, hw_push_ack, hw_pop_valid, hw_empty, hw_full;
  logic [31:0] bus_rdata, hw_pop_data;

  int checks = 0;
  int failures = 0;
  logic [31:0] model_q[$];

  always #2 clk = ~clk;

  mmio_fifo_queue #(.DEPTH(DEPTH)) u_mmio_fifo_queue (
    .clk, .rst_n, .bus_valid, .bus_ready, .bus_write, .bus_addr, .bus_wdata,
    .bus_rvalid, .bus_rdata, .hw_push, .hw_push_data, .hw_push_ack,
    .hw_pop, .hw_pop_valid, .hw_pop_data, .hw_empty, .hw_full
  );

  function automatic logic [31:0] status_word(input int n);
    logic [31:0] s;
    s = 32'(n) << 2;
    if (n == DEPTH) s[1] = 1'b1;
    if (n == 0)     s[0] = 1'b1;
    return s;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: drive at a falling edge, check the registered results one falling edge later
  task automatic step(input logic bv, input logic bw, input logic [3:0] ba, input logic [31:0] bd,
                      input logic hpu, input logic [31:0] hd, input logic hpo);
    bit bpop, bpush, hpo_f, hpu_f, pop_ok, push_ok, exp_rv, exp_hv;
    logic [31:0] popped, exp_stat, exp_rd;
    string tag;
    bus_valid = bv; bus_write = bw; bus_addr = ba; bus_wdata = bd;
    hw_push = hpu; hw_push_data = hd; hw_pop = hpo;
    bpop   = bv && !bw && (ba == 4'h0);
    bpush  = bv && bw && (ba == 4'h0);
    hpo_f  = hpo && !bpop;
    hpu_f  = hpu && !bpush;
    pop_ok = (bpop || hpo_f) && (model_q.size() > 0);
    push_ok = (bpush || hpu_f) && ((model_q.size() < DEPTH) || pop_ok);
    exp_stat = status_word(model_q.size());
    popped = '0;
    if (pop_ok) popped = model_q[0];
    #1;
    chk("R8 push ack", 32'(hw_push_ack), 32'(hpu_f && push_ok));
    if (pop_ok)  void'(model_q.pop_front());
    if (push_ok) model_q.push_back(bpush ? bd : hd);
    exp_rv = bv && !bw;
    exp_hv = hpo_f && pop_ok;
    if (ba == 4'h0) begin
      exp_rd = (bpop && pop_ok) ? popped : 32'h0;
      tag = pop_ok ? "R2 bus data" : "R5 empty read";
    end else if (ba == 4'h4) begin
      exp_rd = exp_stat; tag = "R6 status";
    end else begin
      exp_rd = 32'h0; tag = "R7 unmapped";
    end
    @(posedge clk);
    @(negedge clk);
    chk("R3 bus rvalid", 32'(bus_rvalid), 32'(exp_rv));
    if (exp_rv) chk(tag, bus_rdata, exp_rd);
    chk("R3 hw pop valid", 32'(hw_pop_valid), 32'(exp_hv));
    if (exp_hv) chk("R2 hw pop data", hw_pop_data, popped);
    chk("R6 empty flag", 32'(hw_empty), 32'(model_q.size() == 0));
    chk("R6 full flag", 32'(hw_full), 32'(model_q.size() == DEPTH));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int r;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: state right after reset
    chk("R1 empty after reset", 32'(hw_empty), 32'd1);
    chk("R1 full after reset", 32'(hw_full), 32'd0);
    chk("R1 no response after reset", 32'(bus_rvalid), 32'd0);
    step(1, 0, 4'h4, 0, 0, 0, 0);  // R1 status read of 0x1

    // R2: fill from both sides, alternating
    for (int i = 0; i < DEPTH; i++) begin
      if (i % 2 == 0) step(1, 1, 4'h0, 32'hA000_0000 + 32'(i), 0, 0, 0);
      else            step(0, 0, 4'h0, 0, 1, 32'hB000_0000 + 32'(i), 0);
    end
    step(1, 0, 4'h4, 0, 0, 0, 0);  // R6 full status
    step(0, 0, 4'h0, 0, 1, 32'hDEAD_0001, 0);  // R5 dropped push on full
    // R4: bus push on full with agent pop in the same cycle
    step(1, 1, 4'h0, 32'hC0DE_0004, 0, 0, 1);
    step(1, 0, 4'h4, 0, 0, 0, 0);
    chk("R4 still full after swap", 32'(hw_full), 32'd1);
    // R8: both pop, then both push
    step(1, 0, 4'h0, 0, 0, 0, 1);
    step(1, 1, 4'h0, 32'h1111_1111, 1, 32'h2222_2222, 0);
    // R7: unmapped offsets
    step(1, 1, 4'h8, 32'hFFFF_FFFF, 0, 0, 0);
    step(1, 0, 4'h8, 0, 0, 0, 0);
    step(1, 0, 4'hC, 0, 0, 0, 0);
    step(1, 0, 4'h4, 0, 0, 0, 0);
    // drain, then pops on empty (R5)
    while (model_q.size() > 0) step(1, 0, 4'h0, 0, 0, 0, 0);
    step(1, 0, 4'h0, 0, 0, 0, 0);
    step(0, 0, 4'h0, 0, 0, 0, 1);
    step(1, 0, 4'h4, 0, 0, 0, 0);

    // random phases: push heavy, balanced, pop heavy
    for (int i = 0; i < 900; i++) begin
      int push_pct, ph;
      logic bv, bw, hpu, hpo;
      logic [3:0] ba;
      ph = i / 300;
      push_pct = (ph == 0) ? 70 : (ph == 1) ? 50 : 25;
      bv  = ($urandom % 100) < 50;
      bw  = ($urandom % 100) < push_pct;
      r   = $urandom % 6;
      ba  = (r < 3) ? 4'h0 : (r == 3) ? 4'h4 : (r == 4) ? 4'h8 : 4'hC;
      hpu = ($urandom % 100) < push_pct;
      hpo = ($urandom % 100) < (100 - push_pct);
      step(bv, bw, ba, $urandom, hpu, $urandom, hpo);
    end
    step(0, 0, 4'h0, 0, 0, 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule